// File: doc/BRIEF.md
# Carry-Chain Cellular Automaton Random Bit Generator

This block is a pseudo-random bit source built from a ring of `CELLS` one-bit automaton cells. Each cell holds a state bit and a meta-state bit. The meta-state picks which of two elementary rules updates the state. A combinational mix bit XORs two state taps at configurable offsets. A carry ripples from cell 0 to the last cell in every cycle and feeds each cell's next meta-state. Every cycle the block presents three bits per cell: state, mix and meta-state.

The carry into cell 0 is a boundary bit XORed with a serial input bit. The boundary bit is chosen at elaboration as constant zero, a registered copy of the last cell's carry out, or a flip-flop that alternates. To seed the generator, clock a seed bitstream in through the serial input after reset. Later injection of outside entropy works the same way. Hold the serial input at 0 for free-running operation. With `en` low the generator holds its whole state.

Top module: `carry_ca_prng`

## Requirements
- R1: After a synchronous reset, state bit i is 1 for even i and 0 for odd i. Meta-state bit i is 1 when i mod 3 is 0 and 0 otherwise. The feedback and toggle flip-flops are 0.
- R2: On an enabled cycle, cell i's next state is bit `idx` of `RULE_A` when its meta-state is 0, and bit `idx` of `RULE_B` when it is 1. Here idx = 4*S[i+1] + 2*S[i] + S[i-1], with indices wrapping modulo `CELLS`.
- R3: The mix bit I[i] equals S[i+MOFF] XOR S[i+NOFF]. It is taken combinationally from the current state bits, with indices wrapping modulo `CELLS`. NOFF is -1, 0 or +1.
- R4: The carry out of cell i is I[i] ? C[i-1] : nextS[i], where C[-1] is the carry into cell 0. The next meta-state of cell i is C[i-1] XOR I[i]. The whole chain resolves within one cycle.
- R5: The carry into cell 0 equals seedBit XOR the boundary bit. seedBit is sampled only on enabled cycles.
- R6: In toggle mode the boundary bit is 0 on the first enabled cycle after reset and inverts on every enabled cycle after that.
- R7: In feedback mode the boundary bit is the last cell's carry out from the previous enabled cycle. It is 0 after reset.
- R8: In zero mode the boundary bit is always 0.
- R9: While `en` is low, all state, meta-state and boundary registers hold, so `rndOut` does not change and seedBit has no effect.
- R10: `rndOut[i]` = S[i] and `rndOut[CELLS+i]` = I[i], for i from 0 to CELLS-1. `rndOut[2*CELLS+j]` carries the meta-state bits in the order M[0], M[CELLS-1], M[1], M[CELLS-2], and so on; for even `CELLS` the order ends with M[CELLS/2-1], M[CELLS/2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the automaton by one step |
| seedBit | input | 1 | Serial seed/entropy bit XORed into the first carry |
| rndOut | output | 3*CELLS | State, mix and interleaved meta-state bits |

## Verification
Assertions check four things on every cycle. The state and meta-state registers hold whenever the step strobe is low. They take the fixed pattern right after reset. The toggle flip-flop inverts on each step. The feedback flip-flop captures the last carry out. The rule lookup, tap wrapping, carry ripple, serial injection and output interleaving can only be shown by the bench's scenarios. A cell-by-cell reference model produces whole output words for three configurations, one per boundary mode, including an odd cell count. These words are compared after seeding, during stalls and in free-running operation.

// File: rtl/cprng_pkg.sv
package cprng_pkg;

  typedef enum logic [1:0] {
    BND_ZERO     = 2'd0,
    BND_FEEDBACK = 2'd1,
    BND_TOGGLE   = 2'd2
  } bnd_mode_e;

  // Strobes from control to the cell array.
  typedef struct packed {
    logic clear;
    logic step;
    logic cin;
  } ctrl_t;

endpackage

// File: rtl/cprng_ctrl.sv
module cprng_ctrl
  import cprng_pkg::*;
#(
  parameter bnd_mode_e BOUNDARY = BND_TOGGLE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  seedBit,
  input  logic  carryOut,
  output ctrl_t ctrl
);

  logic fbQ;
  logic togQ;
  logic boundBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fbQ  <= 1'b0;
      togQ <= 1'b0;
    end else if (en) begin
      fbQ  <= carryOut;
      togQ <= ~togQ;
    end
  end

  always_comb begin
    case (BOUNDARY)
      BND_FEEDBACK: boundBit = fbQ;
      BND_TOGGLE:   boundBit = togQ;
      default:      boundBit = 1'b0;
    endcase
    ctrl.clear = rst;
    ctrl.step  = en & ~rst;
    ctrl.cin   = seedBit ^ boundBit;
  end

  // R6: toggle flop inverts on each step
  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> (togQ != $past(togQ)));

  // R7: feedback flop captures the last carry out on each step
  assert_feedback_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> (fbQ == $past(carryOut)));

endmodule

// File: rtl/cprng_cells.sv
module cprng_cells
  import cprng_pkg::*;
#(
  parameter int         CELLS  = 32,
  parameter logic [7:0] RULE_A = 8'd150,
  parameter logic [7:0] RULE_B = 8'd105,
  parameter int         MOFF   = -4,
  parameter int         NOFF   = 0
) (
  input  logic             clk,
  input  ctrl_t            ctrl,
  output logic             carryOut,
  output logic [CELLS-1:0] stateQ,
  output logic [CELLS-1:0] mixBits,
  output logic [CELLS-1:0] metaQ
);

  function automatic logic [CELLS-1:0] mkInit(input int period);
    logic [CELLS-1:0] v;
    for (int i = 0; i < CELLS; i++) v[i] = ((i % period) == 0);
    return v;
  endfunction

  localparam logic [CELLS-1:0] STATE_INIT = mkInit(2);
  localparam logic [CELLS-1:0] META_INIT  = mkInit(3);

  logic [CELLS-1:0] nextState;
  logic [CELLS-1:0] nextMeta;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int UP  = (i + 1) % CELLS;
    localparam int DN  = (i + CELLS - 1) % CELLS;
    localparam int TPM = ((i + MOFF) % CELLS + CELLS) % CELLS;
    localparam int TPN = ((i + NOFF) % CELLS + CELLS) % CELLS;
    logic [2:0] nbhd;
    assign nbhd         = {stateQ[UP], stateQ[i], stateQ[DN]};
    assign nextState[i] = metaQ[i] ? RULE_B[nbhd] : RULE_A[nbhd];
    assign mixBits[i]   = stateQ[TPM] ^ stateQ[TPN];
  end

  // Ripple carry through the ring, cell 0 first.
  always_comb begin
    logic c;
    c = ctrl.cin;
    for (int i = 0; i < CELLS; i++) begin
      nextMeta[i] = c ^ mixBits[i];
      c = mixBits[i] ? c : nextState[i];
    end
    carryOut = c;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      stateQ <= STATE_INIT;
      metaQ  <= META_INIT;
    end else if (ctrl.step) begin
      stateQ <= nextState;
      metaQ  <= nextMeta;
    end
  end

  // R9: no step, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.step |=> ($stable(stateQ) && $stable(metaQ)));

  // R1: fixed pattern visible right after reset
  assert_reset_R1: assert property (@(posedge clk) disable iff (ctrl.clear)
    $fell(ctrl.clear) |-> (stateQ == STATE_INIT && metaQ == META_INIT));

endmodule

// File: rtl/carry_ca_prng.sv
module carry_ca_prng
  import cprng_pkg::*;
#(
  parameter int         CELLS    = 32,
  parameter logic [7:0] RULE_A   = 8'd150,
  parameter logic [7:0] RULE_B   = 8'd105,
  parameter int         MOFF     = -4,
  parameter int         NOFF     = 0,
  parameter bnd_mode_e  BOUNDARY = BND_TOGGLE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               seedBit,
  output logic [3*CELLS-1:0] rndOut
);

  ctrl_t            ctrl;
  logic             carryOut;
  logic [CELLS-1:0] stateQ;
  logic [CELLS-1:0] mixBits;
  logic [CELLS-1:0] metaQ;

  cprng_ctrl #(.BOUNDARY(BOUNDARY)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .seedBit  (seedBit),
    .carryOut (carryOut),
    .ctrl     (ctrl)
  );

  cprng_cells #(
    .CELLS  (CELLS),
    .RULE_A (RULE_A),
    .RULE_B (RULE_B),
    .MOFF   (MOFF),
    .NOFF   (NOFF)
  ) u_cells (
    .clk      (clk),
    .ctrl     (ctrl),
    .carryOut (carryOut),
    .stateQ   (stateQ),
    .mixBits  (mixBits),
    .metaQ    (metaQ)
  );

  assign rndOut[CELLS-1:0]       = stateQ;
  assign rndOut[2*CELLS-1:CELLS] = mixBits;

  // Interleave meta bits from both ends of the ring.
  for (genvar j = 0; j < CELLS; j++) begin : g_omix
    localparam int SRC = (j % 2 == 0) ? (j / 2) : (CELLS - 1 - j / 2);
    assign rndOut[2*CELLS+j] = metaQ[SRC];
  end

endmodule

// File: tb/tb_carry_ca_prng.sv
module tb_carry_ca_prng;
  import cprng_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic seedBit = 1'b0;
  always #5 clk = ~clk;

  logic [95:0] outA;
  logic [23:0] outB;
  logic [14:0] outC;

  // Model 0: default config, toggle boundary
  carry_ca_prng dut (.clk(clk), .rst(rst), .en(en), .seedBit(seedBit), .rndOut(outA));
  // Model 1: rules 90/165, feedback boundary
  carry_ca_prng #(.CELLS(8), .RULE_A(8'd90), .RULE_B(8'd165), .MOFF(2), .NOFF(-1),
    .BOUNDARY(BND_FEEDBACK)) dutFb (.clk(clk), .rst(rst), .en(en), .seedBit(seedBit), .rndOut(outB));
  // Model 2: odd ring, zero boundary
  carry_ca_prng #(.CELLS(5), .RULE_A(8'd150), .RULE_B(8'd105), .MOFF(-2), .NOFF(1),
    .BOUNDARY(BND_ZERO)) dutZ (.clk(clk), .rst(rst), .en(en), .seedBit(seedBit), .rndOut(outC));

  int cfgK[3]    = '{32, 8, 5};
  int cfgRa[3]   = '{150, 90, 150};
  int cfgRb[3]   = '{105, 165, 105};
  int cfgM[3]    = '{-4, 2, -2};
  int cfgN[3]    = '{0, -1, 1};
  int cfgMode[3] = '{2, 1, 0};
  string cfgTag[3] = '{"R6", "R7", "R8"};

  logic [31:0] mS[3];
  logic [31:0] mM[3];
  logic        mFb[3];
  logic        mTog[3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "";

  function automatic int wrapIdx(input int x, input int k);
    return ((x % k) + k) % k;
  endfunction

  function automatic logic mixAt(input logic [31:0] s, input int i, input int k,
                                 input int mo, input int no);
    return s[wrapIdx(i + mo, k)] ^ s[wrapIdx(i + no, k)];
  endfunction

  function automatic logic [95:0] modelWord(input int q);
    logic [95:0] w = '0;
    int k = cfgK[q];
    int lo = 0;
    int hi = k - 1;
    for (int i = 0; i < k; i++) begin
      w[i]     = mS[q][i];
      w[k + i] = mixAt(mS[q], i, k, cfgM[q], cfgN[q]);
    end
    for (int p = 0; p < k; p++) begin
      if (p % 2 == 0) begin w[2*k + p] = mM[q][lo]; lo++; end
      else            begin w[2*k + p] = mM[q][hi]; hi--; end
    end
    return w;
  endfunction

  function automatic logic [95:0] dutWord(input int q);
    case (q)
      0: return outA;
      1: return {72'd0, outB};
      default: return {81'd0, outC};
    endcase
  endfunction

  task automatic modelReset(input int q);
    mS[q] = '0; mM[q] = '0;
    for (int i = 0; i < cfgK[q]; i++) begin
      mS[q][i] = (i % 2 == 0);
      mM[q][i] = (i % 3 == 0);
    end
    mFb[q] = 1'b0; mTog[q] = 1'b0;
  endtask

  task automatic modelStep(input int q, input logic v);
    int k = cfgK[q];
    logic [7:0] ra = 8'(cfgRa[q]);
    logic [7:0] rb = 8'(cfgRb[q]);
    logic [31:0] ns = '0;
    logic [31:0] nm = '0;
    logic b, c, nx, ix;
    int idx;
    b = (cfgMode[q] == 1) ? mFb[q] : (cfgMode[q] == 2) ? mTog[q] : 1'b0;
    c = v ^ b;
    for (int i = 0; i < k; i++) begin
      idx = 4 * int'(mS[q][wrapIdx(i + 1, k)]) + 2 * int'(mS[q][i]) + int'(mS[q][wrapIdx(i - 1, k)]);
      nx = mM[q][i] ? rb[idx] : ra[idx];
      ix = mixAt(mS[q], i, k, cfgM[q], cfgN[q]);
      nm[i] = c ^ ix;
      if (!ix) c = nx;
      ns[i] = nx;
    end
    mS[q] = ns; mM[q] = nm;
    mFb[q] = c; mTog[q] = ~mTog[q];
  endtask

  task automatic check(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int q = 0; q < 3; q++) begin
      logic [95:0] e = modelWord(q);
      logic [95:0] a = dutWord(q);
      // R2 R3 R4 R5 R10 plus the boundary mode of this instance
      check(a === e, {"R2 R3 R4 R5 R10 ", cfgTag[q]}, a, e);
    end
  endtask

  task automatic cycle(input logic r, input logic e, input logic v);
    rst = r; en = e; seedBit = v;
    @(posedge clk);
    #1;
    for (int q = 0; q < 3; q++) begin
      if (r) modelReset(q);
      else if (e) modelStep(q, v);
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] held[3];
    void'($urandom(32'h5eed_1234));
    for (int q = 0; q < 3; q++) modelReset(q);

    phase = "reset";
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b1, 1'b1, 1'b1);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);
    // R1: direct pattern check on the state field of the default instance
    check(outA[31:0] === 32'h5555_5555, "R1", {64'd0, outA[31:0]}, 96'h5555_5555);
    // R1 R10: meta field M0,M31,M1,M30.. with M[i]=1 when i%3==0
    compareAll();

    phase = "seeding";
    for (int t = 0; t < 48; t++) cycle(1'b0, 1'b1, 1'($urandom_range(0, 1)));

    phase = "stall";
    for (int q = 0; q < 3; q++) held[q] = dutWord(q);
    for (int t = 0; t < 8; t++) begin
      cycle(1'b0, 1'b0, 1'($urandom_range(0, 1)));
      for (int q = 0; q < 3; q++) check(dutWord(q) === held[q], "R9", dutWord(q), held[q]);
    end

    phase = "free-run";
    for (int t = 0; t < 400; t++) cycle(1'b0, ($urandom_range(0, 3) != 0), 1'b0);

    phase = "entropy";
    for (int t = 0; t < 200; t++)
      cycle(1'b0, ($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)));

    phase = "reseed-ones";
    cycle(1'b1, 1'b0, 1'b0);
    for (int t = 0; t < 20; t++) cycle(1'b0, 1'b1, 1'b1);
    for (int t = 0; t < 20; t++) cycle(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule